// File: doc/BRIEF.md
# Memory Bus to DRAM Controller Handshake Bridge

This block sits between an 8-bit CPU memory bus and an external DRAM timing controller that works by acknowledge handshaking. It turns the CPU's memory strobes and board select into read and write commands for the controller. It holds the CPU in a wait state until the controller signals that it has started the access. After each access it enforces a short idle gap before the next command. It also produces a capture strobe for the read-data latch, an output enable for that latch, and a DRAM write enable that can be pushed later in time to suit a CPU whose write data arrives late.

All CPU-side and controller-side inputs are asynchronous to the fast system clock, so each one passes through a two-stage synchronizer. In the rest of this brief, "seen" means the value after those two clock edges. A small state machine tracks one transaction at a time, and a down-counter times the recovery gap. Reset is synchronous and active high.

Top module: `dram_hs_bridge`

## Requirements
- R1: `cpu_wait` is high exactly when a seen read or write strobe is active, the board is selected (seen `bus_sel`, or a command is being driven), and no seen start acknowledge has occurred since that strobe became active.
- R2: Once a start acknowledge is seen during a strobe, `cpu_wait` stays low until that strobe ends, whether or not the completion acknowledge arrived first.
- R3: A command rises on the clock edge after the strobe and select are seen, provided that the seen completion acknowledge is low and no recovery gap is running. While the completion acknowledge is seen high, no command is issued.
- R4: An issued command stays high until the completion acknowledge rises. It then stays high for as long as the matching strobe remains active.
- R5: After a command drops, no new command rises for at least `GAP_CYC` clock cycles (default 13, about 100 ns at 125 MHz).
- R6: `ctl_rd_cmd` and `ctl_wr_cmd` are never high together. When both strobes are seen together, the read command is the one issued.
- R7: While a command is driven, the block keeps treating the board as selected. `cpu_wait` therefore holds even if `bus_sel` has dropped.
- R8: `rdlatch_oe` is high exactly when the seen `bus_sel` and the seen read strobe are both high.
- R9: `latch_capture` is a one-cycle pulse, issued in the cycle in which a rising completion acknowledge is first seen.
- R10: `dram_we` is high only while `ctl_wr_cmd` is high. With `we_delay_en` = 0 it follows the seen `col_strobe`. With `we_delay_en` = 1 it follows the seen `col_strobe` delayed by `WE_DLY` cycles (default 13).
- R11: While `rst` is high, both commands, `cpu_wait`, `latch_capture`, `dram_we` and the recovery gap are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_rd | input | 1 | CPU memory-read strobe, active high, asynchronous |
| bus_wr | input | 1 | CPU memory-write strobe, active high, asynchronous |
| bus_sel | input | 1 | Board select decoded from the CPU address |
| ctl_start_ack | input | 1 | Controller start acknowledge, active high |
| ctl_done_ack | input | 1 | Controller completion acknowledge, active high |
| col_strobe | input | 1 | Column strobe from the controller, active high |
| we_delay_en | input | 1 | Static configuration: 1 delays the DRAM write enable |
| cpu_wait | output | 1 | Wait request to the CPU |
| rdlatch_oe | output | 1 | Output enable of the read-data latch onto the CPU bus |
| ctl_rd_cmd | output | 1 | Read command to the controller |
| ctl_wr_cmd | output | 1 | Write command to the controller |
| latch_capture | output | 1 | Strobe that captures DRAM read data into the latch |
| dram_we | output | 1 | Write enable to the DRAM array |

## Verification
The bench goes after the case where the start acknowledge arrives after the completion acknowledge. A design that ended the wait on completion, or that required a fixed order, would release the CPU early or keep it stuck. It checks that the select is held once the CPU's select drops mid-access; getting this wrong lets the wait fall while the command is still pending. It measures the idle gap between two back-to-back commands, where a missing or short counter shows up as a command reissued too soon. It also checks read priority on coincident strobes, and that no command is issued while the completion acknowledge is high. Random bus and acknowledge traffic is compared every cycle against a bench model of the wait, latch-enable, capture and delayed write-enable rules, and the bench checks that the two commands never overlap.

// File: rtl/dram_hs_pkg.sv
package dram_hs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_HOLD = 2'd2,
        ST_GAP  = 2'd3
    } txn_state_t;

    typedef enum logic {
        KIND_RD = 1'b0,
        KIND_WR = 1'b1
    } cmd_kind_t;

    // Bundle of asynchronous inputs carried through the synchronizer.
    typedef struct packed {
        logic rd;
        logic wr;
        logic sel;
        logic sack;
        logic xack;
        logic col;
    } bus_view_t;

    localparam int VIEW_W = $bits(bus_view_t);

    // Read wins when both strobes are present.
    function automatic cmd_kind_t pick_kind(input logic rd_seen);
        return rd_seen ? KIND_RD : KIND_WR;
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/hs_txn_fsm.sv
module hs_txn_fsm
    import dram_hs_pkg::*;
#(
    parameter int GAP_CYC = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_s,
    input  logic wr_s,
    input  logic sel_s,
    input  logic xack_s,
    input  logic xack_rise,
    output logic rd_cmd,
    output logic wr_cmd
);
    localparam int CNT_W = $clog2(GAP_CYC + 1);

    txn_state_t       state;
    cmd_kind_t        kind;
    logic [CNT_W-1:0] gap_cnt;
    logic             kind_strobe;
    logic             cmd_any;
    logic             can_issue;

    assign kind_strobe = (kind == KIND_RD) ? rd_s : wr_s;
    assign can_issue   = (rd_s || wr_s) && sel_s && !xack_s && (gap_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            kind    <= KIND_RD;
            gap_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (can_issue) begin
                        state <= ST_CMD;
                        kind  <= pick_kind(rd_s);
                    end
                end
                ST_CMD: begin
                    if (xack_rise) begin
                        if (kind_strobe) begin
                            state <= ST_HOLD;
                        end else begin
                            state   <= ST_GAP;
                            gap_cnt <= CNT_W'(GAP_CYC);
                        end
                    end
                end
                ST_HOLD: begin
                    if (!kind_strobe) begin
                        state   <= ST_GAP;
                        gap_cnt <= CNT_W'(GAP_CYC);
                    end
                end
                default: begin
                    if (gap_cnt <= CNT_W'(1)) state <= ST_IDLE;
                    if (gap_cnt != '0) gap_cnt <= gap_cnt - CNT_W'(1);
                end
            endcase
        end
    end

    assign cmd_any = (state == ST_CMD) || (state == ST_HOLD);
    assign rd_cmd  = cmd_any && (kind == KIND_RD);
    assign wr_cmd  = cmd_any && (kind == KIND_WR);

    // R4: a command awaiting completion is never withdrawn early
    assert_cmd_held_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CMD && !xack_rise) |=> (rd_cmd || wr_cmd));

    // R5: a command only starts once the recovery counter has run out
    assert_gap_done_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_any) |-> ($past(gap_cnt) == '0));

    // R3: no command starts while completion acknowledge is high
    assert_no_issue_on_xack_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_any) |-> !$past(xack_s));
endmodule

// File: rtl/hs_we_delay.sv
module hs_we_delay #(
    parameter int DLY = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic col_s,
    input  logic delay_en,
    input  logic wr_cmd,
    output logic dram_we
);
    logic col_late;

    generate
        if (DLY == 0) begin : g_nodly
            assign col_late = col_s;
        end else begin : g_dly
            logic [DLY-1:0] line;
            always_ff @(posedge clk) begin
                if (rst) line <= '0;
                else     line <= {line[DLY-2+((DLY==1)?1:0):0], col_s};
            end
            assign col_late = line[DLY-1];
        end
    endgenerate

    assign dram_we = wr_cmd && (delay_en ? col_late : col_s);

    // R10: with the delay off, a write enable edge follows the column strobe directly
    assert_we_nodelay_R10: assert property (@(posedge clk) disable iff (rst)
        ($rose(dram_we) && !delay_en) |-> col_s);
endmodule

// File: rtl/dram_hs_bridge.sv
module dram_hs_bridge
    import dram_hs_pkg::*;
#(
    parameter int GAP_CYC = 13,
    parameter int WE_DLY  = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_rd,
    input  logic bus_wr,
    input  logic bus_sel,
    input  logic ctl_start_ack,
    input  logic ctl_done_ack,
    input  logic col_strobe,
    input  logic we_delay_en,
    output logic cpu_wait,
    output logic rdlatch_oe,
    output logic ctl_rd_cmd,
    output logic ctl_wr_cmd,
    output logic latch_capture,
    output logic dram_we
);
    bus_view_t raw_v, seen_v;
    logic      xack_q;
    logic      start_seen;
    logic      strobe_s;
    logic      sel_int;

    assign raw_v = '{rd: bus_rd, wr: bus_wr, sel: bus_sel,
                     sack: ctl_start_ack, xack: ctl_done_ack, col: col_strobe};

    hs_sync #(.WIDTH(VIEW_W), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw_v),
        .dout(seen_v)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            xack_q     <= 1'b0;
            start_seen <= 1'b0;
        end else begin
            xack_q <= seen_v.xack;
            if (!strobe_s)        start_seen <= 1'b0;
            else if (seen_v.sack) start_seen <= 1'b1;
        end
    end

    assign strobe_s      = seen_v.rd || seen_v.wr;
    assign latch_capture = seen_v.xack && !xack_q;

    hs_txn_fsm #(.GAP_CYC(GAP_CYC)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .rd_s     (seen_v.rd),
        .wr_s     (seen_v.wr),
        .sel_s    (seen_v.sel),
        .xack_s   (seen_v.xack),
        .xack_rise(latch_capture),
        .rd_cmd   (ctl_rd_cmd),
        .wr_cmd   (ctl_wr_cmd)
    );

    hs_we_delay #(.DLY(WE_DLY)) u_we (
        .clk     (clk),
        .rst     (rst),
        .col_s   (seen_v.col),
        .delay_en(we_delay_en),
        .wr_cmd  (ctl_wr_cmd),
        .dram_we (dram_we)
    );

    assign sel_int    = seen_v.sel || ctl_rd_cmd || ctl_wr_cmd;
    assign cpu_wait   = strobe_s && sel_int && !(start_seen || seen_v.sack);
    assign rdlatch_oe = seen_v.sel && seen_v.rd;

    // R6: the two commands are mutually exclusive
    assert_cmd_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(ctl_rd_cmd && ctl_wr_cmd));

    // R2: a start acknowledge during a strobe releases the wait on the next cycle
    assert_wait_release_R2: assert property (@(posedge clk) disable iff (rst)
        (seen_v.sack && strobe_s) |=> !cpu_wait);

    // R7: a driven command keeps the CPU waiting without its select
    assert_sel_hold_R7: assert property (@(posedge clk) disable iff (rst)
        ((ctl_rd_cmd || ctl_wr_cmd) && strobe_s && !start_seen && !seen_v.sack) |-> cpu_wait);

    // R9: the capture strobe lasts a single cycle
    assert_capture_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        latch_capture |=> !latch_capture);

    // R11: reset clears the commands and the wait
    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (!ctl_rd_cmd && !ctl_wr_cmd && !cpu_wait));
endmodule

// File: tb/sim_dram_hs_bridge.sv
`timescale 1ns/1ps
module sim_dram_hs_bridge;
    localparam int GAP_CYC = 13;
    localparam int WE_DLY  = 13;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_rd = 0, bus_wr = 0, bus_sel = 0;
    logic sack = 0, xack = 0, col = 0, den = 0;
    logic cpu_wait, rdlatch_oe, ctl_rd_cmd, ctl_wr_cmd, latch_capture, dram_we;

    int checks = 0;
    int fails  = 0;
    bit model_on = 0;

    always #4 clk = ~clk;

    dram_hs_bridge #(.GAP_CYC(GAP_CYC), .WE_DLY(WE_DLY)) u0 (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .ctl_start_ack(sack), .ctl_done_ack(xack), .col_strobe(col),
        .we_delay_en(den), .cpu_wait(cpu_wait), .rdlatch_oe(rdlatch_oe),
        .ctl_rd_cmd(ctl_rd_cmd), .ctl_wr_cmd(ctl_wr_cmd),
        .latch_capture(latch_capture), .dram_we(dram_we));

    // Bench view of the inputs after the two-edge synchronization.
    logic [5:0] b1, b2;
    logic       b3x, seen;
    logic [WE_DLY-1:0] colh;

    always @(posedge clk) begin
        if (rst) begin
            b1 <= '0; b2 <= '0; b3x <= 0; seen <= 0; colh <= '0;
        end else begin
            b1   <= {bus_rd, bus_wr, bus_sel, sack, xack, col};
            b2   <= b1;
            b3x  <= b2[1];
            colh <= {colh[WE_DLY-2:0], b2[0]};
            if (!(b2[5] || b2[4])) seen <= 0;
            else if (b2[2])        seen <= 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_wait();
        return (b2[5] || b2[4]) && (b2[3] || ctl_rd_cmd || ctl_wr_cmd) && !(seen || b2[2]);
    endfunction

    function automatic bit exp_we();
        return ctl_wr_cmd && (den ? colh[WE_DLY-1] : b2[0]);
    endfunction

    // Per-cycle comparison against the bench rules.
    always @(negedge clk) begin
        if (model_on && !rst) begin
            check(cpu_wait == exp_wait(), "R1", cpu_wait, exp_wait());
            check(rdlatch_oe == (b2[3] && b2[5]), "R8", rdlatch_oe, b2[3] && b2[5]);
            check(!(ctl_rd_cmd && ctl_wr_cmd), "R6", ctl_rd_cmd + ctl_wr_cmd, 1);
            check(latch_capture == (b2[1] && !b3x), "R9", latch_capture, b2[1] && !b3x);
            check(dram_we == exp_we(), "R10", dram_we, exp_we());
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic idle(input int n);
        bus_rd = 0; bus_wr = 0; bus_sel = 0; sack = 0; xack = 0; col = 0;
        tick(n);
    endtask

    task automatic wait_cmd(output bit got);
        got = 0;
        for (int i = 0; i < 40 && !got; i++) begin
            tick(1);
            got = ctl_rd_cmd || ctl_wr_cmd;
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        bit got;
        int lows;
        void'($urandom(32'd20240611));
        tick(4);
        // R11: reset state
        check(!ctl_rd_cmd && !ctl_wr_cmd && !cpu_wait && !latch_capture && !dram_we,
              "R11", ctl_rd_cmd + ctl_wr_cmd + cpu_wait, 0);
        rst = 0;
        model_on = 1;
        tick(3);

        // R3 + R6: coincident strobes, read issued on the third edge
        bus_rd = 1; bus_wr = 1; bus_sel = 1;
        tick(2);
        check(!ctl_rd_cmd, "R3", ctl_rd_cmd, 0);
        tick(1);
        check(ctl_rd_cmd && !ctl_wr_cmd, "R6", {ctl_rd_cmd, ctl_wr_cmd}, 2);

        // R4: command outlives the strobe until completion
        bus_rd = 0; bus_wr = 0; bus_sel = 0;
        tick(6);
        check(ctl_rd_cmd, "R4", ctl_rd_cmd, 1);
        xack = 1;
        tick(5);
        check(!ctl_rd_cmd, "R4", ctl_rd_cmd, 0);
        idle(GAP_CYC + 6);

        // R5: gap between two commands
        bus_wr = 1; bus_sel = 1;
        wait_cmd(got);
        check(got && ctl_wr_cmd, "R5", ctl_wr_cmd, 1);
        bus_wr = 0;
        tick(2);
        xack = 1;
        for (int i = 0; i < 10 && ctl_wr_cmd; i++) tick(1);
        xack = 0; bus_rd = 1;
        lows = 0;
        for (int i = 0; i < 60 && !ctl_rd_cmd; i++) begin
            lows++;
            tick(1);
        end
        check(lows >= GAP_CYC && lows <= GAP_CYC + 3, "R5", lows, GAP_CYC);
        bus_rd = 0; bus_sel = 0;
        tick(2);
        xack = 1; tick(5);
        idle(GAP_CYC + 6);

        // R3: completion acknowledge high blocks issue
        xack = 1; tick(3);
        bus_wr = 1; bus_sel = 1;
        tick(8);
        check(!ctl_wr_cmd && !ctl_rd_cmd, "R3", ctl_wr_cmd, 0);
        idle(GAP_CYC + 6);

        // R7: select dropped mid-access keeps the wait
        bus_wr = 1; bus_sel = 1;
        wait_cmd(got);
        bus_sel = 0;
        tick(4);
        check(cpu_wait, "R7", cpu_wait, 1);
        sack = 1; tick(4);
        check(!cpu_wait, "R2", cpu_wait, 0);
        bus_wr = 0; xack = 1; tick(5);
        idle(GAP_CYC + 6);

        // R2: start acknowledge after completion acknowledge
        bus_rd = 1; bus_sel = 1;
        wait_cmd(got);
        xack = 1; tick(4);
        check(cpu_wait && ctl_rd_cmd, "R2", {cpu_wait, ctl_rd_cmd}, 3);
        sack = 1; tick(4);
        check(!cpu_wait, "R2", cpu_wait, 0);
        bus_rd = 0; tick(4);
        check(!ctl_rd_cmd, "R4", ctl_rd_cmd, 0);
        idle(GAP_CYC + 6);

        // R10: write enable, direct and delayed
        den = 0; bus_wr = 1; bus_sel = 1; sack = 1;
        wait_cmd(got);
        col = 1; tick(2);
        check(dram_we, "R10", dram_we, 1);
        col = 0; tick(3);
        den = 1; tick(WE_DLY + 2);
        col = 1; tick(WE_DLY + 1);
        check(!dram_we, "R10", dram_we, 0);
        tick(1);
        check(dram_we, "R10", dram_we, 1);
        col = 0; bus_wr = 0; xack = 1; tick(WE_DLY + 4);
        idle(GAP_CYC + 6);

        // Random traffic, checked every cycle by the model
        for (int n = 0; n < 4000; n++) begin
            bus_rd  = ($urandom % 8) == 0 ? ~bus_rd  : bus_rd;
            bus_wr  = ($urandom % 8) == 0 ? ~bus_wr  : bus_wr;
            bus_sel = ($urandom % 6) == 0 ? ~bus_sel : bus_sel;
            sack    = ($urandom % 5) == 0 ? ~sack    : sack;
            xack    = ($urandom % 5) == 0 ? ~xack    : xack;
            col     = ($urandom % 3) == 0 ? ~col     : col;
            den     = ($urandom % 200) == 0 ? ~den   : den;
            tick(1);
        end

        // R11: reset in the middle of an access
        idle(GAP_CYC + 6);
        bus_wr = 1; bus_sel = 1;
        wait_cmd(got);
        rst = 1; tick(1);
        check(!ctl_wr_cmd && !cpu_wait, "R11", ctl_wr_cmd + cpu_wait, 0);
        rst = 0; bus_wr = 0; bus_sel = 0;
        tick(4);
        summary();
    end
endmodule